// File: doc/BRIEF.md
# Dual-Predicated Vector Move Sequencer

This block carries out a compressed integer register move that turns into a multi-element copy whenever the per-register tag table marks the source or the destination register as a vector. The instruction encoding is the same as the scalar move. A vector-tagged register number is replaced by the base register held in its table entry. The move then walks two separate element indices, one for each side, and emits one register-file read and one register-file write per element.

Each side has its own 32-bit predicate mask, one bit per element. On a vector side, elements whose bit is clear are skipped without a copy. Because the two sides skip independently, the move can gather scattered source elements into a packed destination, or scatter a packed source into chosen destination slots. A scalar source is broadcast. A scalar destination takes a single element. A move with two scalar operands is a plain one-shot move.

The register file is outside the block. It has one synchronous read port, whose data returns on the cycle after the address, and one write port. A host loads the tag table through a write port, presents the instruction, the masks and the vector length, and pulses start. It then waits for the done pulse.

Top module: `dual_pred_move`

## Requirements
- R1: Instruction bits 11:7 name the destination register and bits 6:2 name the source register. A start is accepted only while idle and only if bits 15:12 equal 4'b1000 and bits 1:0 equal 2'b10. Any other start leaves the block idle, raises no done and writes nothing.
- R2: Each of the 32 table entries holds a vector flag and a 5-bit base register. The entries for the source and destination registers are captured at start. A flagged register is replaced by its base, and an unflagged register keeps its own number.
- R3: When neither operand is flagged, exactly one copy from source to destination is made, whatever the vector length and the masks.
- R4: When the source is a vector, source elements whose source mask bit is clear are never read, and the source index moves past each copied element.
- R5: When the destination is a vector, destination elements whose destination mask bit is clear are never written.
- R6: A scalar source with a vector destination copies the same source register into every enabled destination element below the vector length. The source mask is ignored in this case.
- R7: A vector source with a scalar destination writes at most one value, which is the first enabled source element. The destination mask is ignored in this case.
- R8: Copying stops as soon as either effective index reaches the vector length. A length of 0 with a vector operand writes nothing. A length above 32 is treated as 32.
- R9: Element k of a vector side addresses register (base + k) modulo 32.
- R10: A copy whose target is register 0 issues no write.
- R11: Element copies take effect in order. A read of a register written by the previous element returns the newly written value.
- R12: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse in the first cycle with busy low. A start while busy is ignored.
- R13: A write is only issued in the cycle after the read that supplies its data, and reads are issued only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move with the current instruction and operands |
| instr | input | 16 | Compressed move instruction |
| tbl_we | input | 1 | Tag table write enable |
| tbl_addr | input | 5 | Tag table entry to write |
| tbl_vec | input | 1 | Vector flag for the written entry |
| tbl_base | input | 5 | Base register for the written entry |
| src_mask | input | MAXVL | Source predicate, one bit per element |
| dst_mask | input | MAXVL | Destination predicate, one bit per element |
| vlen | input | VW | Vector length |
| rf_rd_en | output | 1 | Register file read request |
| rf_rd_addr | output | 5 | Register file read address |
| rf_rd_data | input | XLEN | Read data, valid the cycle after the request |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | 5 | Register file write address |
| rf_wr_data | output | XLEN | Register file write data |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, the handshake properties that hold regardless of the data: register 0 never receives a write, every write follows a read, reads occur only while busy, and done is a lone pulse that coincides with busy falling. The value-dependent behaviours can only be shown by the bench scenarios, which compare the final register file against an independent sequential model. These include compressing and expanding under the two masks, broadcast, single-element capture, wrap past register 31, the length clamp, and read-after-write between neighbouring elements on overlapping ranges.

// File: rtl/mv_pkg.sv
package mv_pkg;
  localparam int REG_W = 5;
  localparam int NREG  = 1 << REG_W;
  localparam logic [3:0] MV_FUNCT4 = 4'b1000;
  localparam logic [1:0] MV_QUAD   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } mv_state_e;
endpackage

// File: rtl/mv_reg_table.sv
module mv_reg_table
  import mv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] waddr,
  input  logic             wvec,
  input  logic [REG_W-1:0] wbase,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  output logic             vec_a,
  output logic [REG_W-1:0] base_a,
  output logic             vec_b,
  output logic [REG_W-1:0] base_b
);
  logic [NREG-1:0]  vec_q;
  logic [REG_W-1:0] base_q [NREG];

  // flags reset so that every register starts scalar
  for (genvar e = 0; e < NREG; e++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) vec_q[e] <= 1'b0;
      else if (we && (waddr == REG_W'(e))) vec_q[e] <= wvec;
    end
  end

  // base field kept free of reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (we) base_q[waddr] <= wbase;
  end

  assign vec_a  = vec_q[ra];
  assign base_a = vec_q[ra] ? base_q[ra] : ra;
  assign vec_b  = vec_q[rb];
  assign base_b = vec_q[rb] ? base_q[rb] : rb;
endmodule

// File: rtl/mv_skip_scan.sv
module mv_skip_scan #(
  parameter int W  = 32,
  parameter int VW = $clog2(W + 1)
) (
  input  logic [W-1:0]  mask,
  input  logic [VW-1:0] from,
  output logic [VW-1:0] hit
);
  // lowest enabled element at or above 'from', W when none remains
  always_comb begin
    hit = VW'(W);
    for (int k = W - 1; k >= 0; k--) begin
      if (mask[k] && (k >= int'(from))) hit = VW'(k);
    end
  end
endmodule

// File: rtl/dual_pred_move.sv
module dual_pred_move
  import mv_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MAXVL = 32,
  parameter int VW    = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [15:0]      instr,
  input  logic             tbl_we,
  input  logic [REG_W-1:0] tbl_addr,
  input  logic             tbl_vec,
  input  logic [REG_W-1:0] tbl_base,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic [VW-1:0]    vlen,
  output logic             rf_rd_en,
  output logic [REG_W-1:0] rf_rd_addr,
  input  logic [XLEN-1:0]  rf_rd_data,
  output logic             rf_wr_en,
  output logic [REG_W-1:0] rf_wr_addr,
  output logic [XLEN-1:0]  rf_wr_data,
  output logic             busy,
  output logic             done
);
  localparam logic [VW-1:0] VL_CAP = VW'(MAXVL);

  // instruction fields
  logic [REG_W-1:0] rd_f, rs_f;
  logic             enc_ok;
  assign rd_f   = instr[11:7];
  assign rs_f   = instr[6:2];
  assign enc_ok = (instr[15:12] == MV_FUNCT4) && (instr[1:0] == MV_QUAD);

  // tag table
  logic             t_svec, t_dvec;
  logic [REG_W-1:0] t_sbase, t_dbase;

  mv_reg_table u_tbl (
    .clk    (clk),
    .rst    (rst),
    .we     (tbl_we),
    .waddr  (tbl_addr),
    .wvec   (tbl_vec),
    .wbase  (tbl_base),
    .ra     (rs_f),
    .rb     (rd_f),
    .vec_a  (t_svec),
    .base_a (t_sbase),
    .vec_b  (t_dvec),
    .base_b (t_dbase)
  );

  // captured operands
  mv_state_e        state_q;
  logic             s_vec_q, d_vec_q;
  logic [REG_W-1:0] s_base_q, d_base_q;
  logic [MAXVL-1:0] s_mask_q, d_mask_q;
  logic [VW-1:0]    vl_q;
  logic [VW-1:0]    s_idx_q, d_idx_q;

  // write stage
  logic             p_we_q;
  logic [REG_W-1:0] p_addr_q;
  logic             fwd_q;
  logic [XLEN-1:0]  wdata_q;
  logic             done_q;

  // per-side skip scanners, one per predicate
  logic [MAXVL-1:0] scan_mask [2];
  logic [VW-1:0]    scan_from [2];
  logic [VW-1:0]    scan_hit  [2];
  assign scan_mask[0] = s_mask_q;
  assign scan_mask[1] = d_mask_q;
  assign scan_from[0] = s_idx_q;
  assign scan_from[1] = d_idx_q;

  for (genvar g = 0; g < 2; g++) begin : g_scan
    mv_skip_scan #(.W(MAXVL), .VW(VW)) u_scan (
      .mask (scan_mask[g]),
      .from (scan_from[g]),
      .hit  (scan_hit[g])
    );
  end

  // element step
  logic [VW-1:0]    s_eff, d_eff;
  logic             both_scalar, in_range, issue;
  logic [REG_W-1:0] rd_addr_c, wr_addr_c;

  always_comb begin
    s_eff       = s_vec_q ? scan_hit[0] : s_idx_q;
    d_eff       = d_vec_q ? scan_hit[1] : d_idx_q;
    both_scalar = !s_vec_q && !d_vec_q;
    in_range    = (s_eff < vl_q) && (d_eff < vl_q);
    issue       = (state_q == ST_RUN) && (both_scalar || in_range);
    rd_addr_c   = s_base_q + REG_W'(s_eff);
    wr_addr_c   = d_base_q + REG_W'(d_eff);
  end

  assign rf_rd_en   = issue;
  assign rf_rd_addr = rd_addr_c;
  assign rf_wr_en   = p_we_q;
  assign rf_wr_addr = p_addr_q;
  assign rf_wr_data = fwd_q ? wdata_q : rf_rd_data;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      p_we_q  <= 1'b0;
      fwd_q   <= 1'b0;
      done_q  <= 1'b0;
      s_idx_q <= '0;
      d_idx_q <= '0;
    end else begin
      done_q   <= (state_q == ST_FIN);
      p_we_q   <= issue && (wr_addr_c != '0);
      p_addr_q <= wr_addr_c;
      // read issued while the previous element's write is in flight
      fwd_q    <= issue && p_we_q && (p_addr_q == rd_addr_c);
      if (p_we_q) wdata_q <= rf_wr_data;

      case (state_q)
        ST_IDLE: begin
          if (start && enc_ok) begin
            s_vec_q  <= t_svec;
            d_vec_q  <= t_dvec;
            s_base_q <= t_sbase;
            d_base_q <= t_dbase;
            s_mask_q <= src_mask;
            d_mask_q <= dst_mask;
            vl_q     <= (vlen > VL_CAP) ? VL_CAP : vlen;
            s_idx_q  <= '0;
            d_idx_q  <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (issue) begin
            if (s_vec_q) s_idx_q <= s_eff + VW'(1);
            if (d_vec_q) d_idx_q <= d_eff + VW'(1);
            if (!d_vec_q) state_q <= ST_FIN;
          end else begin
            state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_pred_move_chk.sv
module dual_pred_move_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       rf_rd_en,
  input logic       rf_wr_en,
  input logic [4:0] rf_wr_addr
);
  assert_no_x0_write_R10: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (rf_wr_addr != 5'd0));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_ends_done_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_read_busy_R13: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |-> busy);

  assert_write_after_read_R13: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> $past(rf_rd_en));
endmodule

bind dual_pred_move dual_pred_move_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .rf_rd_en   (rf_rd_en),
  .rf_wr_en   (rf_wr_en),
  .rf_wr_addr (rf_wr_addr)
);

// File: tb/dual_pred_move_bench.sv
module dual_pred_move_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic        tbl_vec = 1'b0;
  logic [4:0]  tbl_base = '0;
  logic [31:0] src_mask = '0, dst_mask = '0;
  logic [5:0]  vlen = '0;
  logic        rf_rd_en, rf_wr_en, busy, done;
  logic [4:0]  rf_rd_addr, rf_wr_addr;
  logic [31:0] rf_rd_data, rf_wr_data;

  logic [31:0] mem   [32];
  logic [31:0] fillv [32];
  logic [31:0] expm  [32];
  logic        fill = 1'b0;
  logic        tvec  [32];
  logic [4:0]  tbase [32];

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  dual_pred_move u_dual_pred_move (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_vec(tbl_vec), .tbl_base(tbl_base),
    .src_mask(src_mask), .dst_mask(dst_mask), .vlen(vlen),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .busy(busy), .done(done)
  );

  // register file model: synchronous read-first, one write port
  always @(posedge clk) begin
    if (fill) begin
      for (int k = 0; k < 32; k++) mem[k] <= (k == 0) ? 32'd0 : fillv[k];
    end else begin
      if (rf_rd_en) rf_rd_data <= mem[rf_rd_addr];
      if (rf_wr_en) mem[rf_wr_addr] <= rf_wr_data;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic refill();
    for (int k = 0; k < 32; k++) fillv[k] = $urandom;
    @(negedge clk) fill = 1'b1;
    @(negedge clk) fill = 1'b0;
  endtask

  task automatic set_tbl(input logic [4:0] r, input logic v, input logic [4:0] b);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = r; tbl_vec = v; tbl_base = b;
    @(negedge clk);
    tbl_we = 1'b0;
    tvec[r] = v; tbase[r] = b;
  endtask

  function automatic logic [15:0] mv_op(input logic [4:0] rd, input logic [4:0] rs);
    return {4'b1000, rd, rs, 2'b10};
  endfunction

  // sequential reference of the dual-predicated move
  task automatic model(input logic [15:0] ins, input logic [31:0] sm,
                       input logic [31:0] dm, input logic [5:0] vl);
    logic sv, dv;
    logic [4:0] sb, db, a, b;
    int i, j, vlc;
    sv = tvec[ins[6:2]];  sb = sv ? tbase[ins[6:2]]  : ins[6:2];
    dv = tvec[ins[11:7]]; db = dv ? tbase[ins[11:7]] : ins[11:7];
    vlc = (vl > 6'd32) ? 32 : int'(vl);
    for (int k = 0; k < 32; k++) expm[k] = mem[k];
    if (!sv && !dv) begin
      if (db != 5'd0) expm[db] = expm[sb];
    end else begin
      i = 0; j = 0;
      while (1) begin
        if (sv) while (i < vlc && !sm[i]) i++;
        if (dv) while (j < vlc && !dm[j]) j++;
        if (i >= vlc || j >= vlc) break;
        a = 5'(int'(sb) + i);
        b = 5'(int'(db) + j);
        if (b != 5'd0) expm[b] = expm[a];
        if (!dv) break;
        if (sv) i++;
        j++;
      end
    end
  endtask

  task automatic run_move(input logic [15:0] ins, input logic [31:0] sm,
                          input logic [31:0] dm, input logic [5:0] vl,
                          input string req, input bit extra_start);
    int n;
    int bad;
    model(ins, sm, dm, vl);
    @(negedge clk);
    instr = ins; src_mask = sm; dst_mask = dm; vlen = vl; start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R12", {req, " busy after start"}, 32'(busy), 32'd1);
    if (extra_start) begin
      instr = mv_op(5'd3, 5'd9);
      src_mask = ~sm; dst_mask = ~dm;
      @(negedge clk);
    end
    start = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R12", {req, " done seen"}, 32'(done), 32'd1);
    chk(busy == 1'b0, "R12", {req, " busy low at done"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R12", {req, " done single pulse"}, 32'(done), 32'd0);
    if (extra_start)
      chk(busy == 1'b0, "R12", {req, " start while busy not queued"}, 32'(busy), 32'd0);
    bad = -1;
    for (int k = 31; k >= 0; k--) if (mem[k] !== expm[k]) bad = k;
    if (bad >= 0)
      chk(1'b0, req, $sformatf("register x%0d", bad), mem[bad], expm[bad]);
    else
      chk(1'b1, req, "register file", 32'd0, 32'd0);
  endtask

  initial begin
    logic [4:0] rs, rd;
    logic [31:0] sm, dm;
    void'($urandom(32'd4711));
    for (int k = 0; k < 32; k++) begin tvec[k] = 1'b0; tbase[k] = '0; end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rf_wr_en == 1'b0 && rf_rd_en == 1'b0,
        "R12", "reset outputs", {28'd0, busy, done, rf_wr_en, rf_rd_en}, 32'd0);
    rst = 1'b0;
    refill();

    // R3: scalar to scalar, length 0 still moves one value
    run_move(mv_op(5'd7, 5'd12), 32'h0, 32'h0, 6'd0, "R3", 1'b0);

    // R1: wrong funct4 and wrong quadrant are ignored
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 32; k++) expm[k] = mem[k];
      @(negedge clk);
      instr = (t == 0) ? {4'b1001, 5'd4, 5'd5, 2'b10} : {4'b1000, 5'd4, 5'd5, 2'b01};
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int c = 0; c < 4; c++) begin
        chk(busy == 1'b0 && done == 1'b0, "R1", "bad encoding stays idle",
            {30'd0, busy, done}, 32'd0);
        @(negedge clk);
      end
      chk(mem[4] === expm[4], "R1", "bad encoding no write", mem[4], expm[4]);
    end

    // R2 R4 R5: vector to vector, both masks compress and expand
    set_tbl(5'd2, 1'b1, 5'd8);
    set_tbl(5'd3, 1'b1, 5'd20);
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'h0000_00A5, 32'h0000_0F0F, 6'd8, "R4", 1'b0);
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'hFFFF_FFFF, 32'h0000_0093, 6'd8, "R5", 1'b0);

    // R6: scalar source broadcast into vector destination
    refill();
    run_move(mv_op(5'd3, 5'd17), 32'h0, 32'h0000_0036, 6'd7, "R6", 1'b0);

    // R7: vector source into scalar destination, first enabled element only
    refill();
    run_move(mv_op(5'd6, 5'd2), 32'h0000_0C00, 32'h0, 6'd16, "R7", 1'b0);

    // R8: vector with length 0 writes nothing; length 40 clamps to 32
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd0, "R8", 1'b0);
    set_tbl(5'd2, 1'b1, 5'd1);
    set_tbl(5'd3, 1'b1, 5'd0);
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd40, "R8", 1'b0);

    // R9: destination range wraps past x31
    set_tbl(5'd3, 1'b1, 5'd29);
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd6, "R9", 1'b0);

    // R10: scalar write to x0 suppressed
    refill();
    run_move(mv_op(5'd0, 5'd9), 32'h0, 32'h0, 6'd1, "R10", 1'b0);

    // R11: overlapping ranges, each element reads the one just written
    set_tbl(5'd2, 1'b1, 5'd4);
    set_tbl(5'd3, 1'b1, 5'd5);
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd6, "R11", 1'b0);

    // R12: start during a run is ignored
    refill();
    run_move(mv_op(5'd3, 5'd2), 32'h0000_00FF, 32'h0000_00FF, 6'd8, "R12", 1'b1);

    // constrained random mix (R13 write ordering covered through the results)
    for (int t = 0; t < 300; t++) begin
      rs = 5'($urandom); rd = 5'($urandom);
      set_tbl(rs, 1'($urandom), 5'($urandom));
      set_tbl(rd, 1'($urandom), 5'($urandom));
      case ($urandom_range(0, 3))
        0: begin sm = $urandom & $urandom; dm = $urandom | $urandom; end
        1: begin sm = 32'hFFFF_FFFF;       dm = $urandom; end
        2: begin sm = $urandom;            dm = 32'hFFFF_FFFF; end
        default: begin sm = $urandom;      dm = $urandom & $urandom; end
      endcase
      if (t % 25 == 0) refill();
      run_move(mv_op(rd, rs), sm, dm, 6'($urandom_range(0, 40)), "R13", (t % 10) == 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule